// File: doc/BRIEF.md
# Quantized Dense Layer Engine

This block evaluates one fully connected neural-network layer on 8-bit integer activations. A start pulse opens a run; the block then takes exactly `N_IN` signed input activations, one per valid/ready handshake. Each output neuron has its own multiply-accumulate lane, so every lane updates on every accepted element. A layer with `N_IN` inputs therefore needs `N_IN` accepting cycles plus one finalisation cycle.

Weights and biases sit in constant lookup tables computed at elaboration, so each lane holds its own column. When the last element has been absorbed, each lane applies ReLU, divides by a power of two with an arithmetic right shift of `SHIFT` bits, and clamps the result to 0..127. All lanes are registered onto a parallel output vector together with a one-cycle done pulse. The lane count is fixed. A layer with fewer real neurons (`N_USED`) leaves the extra lanes with zero weights and zero bias.

Top module: `dense_layer_engine`

## Requirements
- R1: While rst_n is low and after it is released, in_ready and done are 0 and every byte of out_vec is 0.
- R2: A start pulse while idle opens a run and in_ready is 1 from the next cycle. in_valid and start have no effect on the outputs before a run is open.
- R3: A run accepts exactly N_IN elements, one in each cycle where in_valid and in_ready are both 1. Cycles with in_valid low add nothing and do not advance the element index.
- R4: Lane j (j < N_USED) computes acc = bias(j) + sum over k of x[k]*w(j,k), wrapping modulo 2^16 as a signed 16-bit value. Here w(j,k) = ((3j + 5k) mod 11) - 5 and bias(j) = 24j - 40. Its output byte sits at out_vec[8j+7:8j].
- R5: A negative lane sum becomes 0 before shifting (ReLU), and a non-negative one is divided by 2^SHIFT with an arithmetic right shift.
- R6: A shifted value above 127 is output as 127, so bit 7 of every output byte is always 0.
- R7: From the cycle after the last element is accepted, in_ready is 0. done is 1 for exactly one cycle, two cycles after the accepting edge, and the new out_vec appears in that same cycle.
- R8: out_vec changes only in a cycle where done is 1, and it otherwise holds its value, including across idle periods.
- R9: A start pulse during an open run or its finalisation is ignored, and the run's result is unaffected.
- R10: Lanes j >= N_USED have zero weights and zero bias, so their output byte is always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Opens a run when idle |
| in_valid | input | 1 | Input element valid |
| in_data | input | 8 | Signed input activation |
| in_ready | output | 1 | Engine accepts an element this cycle |
| done | output | 1 | One-cycle pulse: results registered |
| out_vec | output | 8*N_LANES | Lane j result at bits 8j+7..8j |

## Verification
On every cycle, the assertions check the output range and the padded lanes. They also check that out_vec moves only with done, that done lasts one cycle, that in_ready stays low once the last element is in, and the fixed distance from the last handshake to done. The arithmetic itself can only be shown by the bench's scenarios. These are the bias and weight tables, the ReLU cut-off, the shift and the clamp. The same goes for gap tolerance, for the rejection of data and start pulses outside an open run, and for the stability of results across idle time.

// File: rtl/dle_pkg.sv
// Shared definitions for the dense layer engine: run states and the
// constant weight and bias tables. Assumes lane and element indices
// are small non-negative integers.
package dle_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } run_state_t;

    // Weight of element idx for neuron lane; unused lanes get zero.
    function automatic logic signed [7:0] weight_of(input int lane, input int idx,
                                                    input int n_used);
        int v;
        if (lane >= n_used) return 8'sd0;
        v = ((3 * lane + 5 * idx) % 11) - 5;
        return 8'(v);
    endfunction

    // Bias of a neuron lane; unused lanes get zero.
    function automatic int bias_of(input int lane, input int n_used);
        if (lane >= n_used) return 0;
        return 24 * lane - 40;
    endfunction

endpackage

// File: rtl/dle_sequencer.sv
// Run control for the dense layer engine. Opens a run on start while
// idle, counts N_IN accepted elements, then spends one cycle in
// finalisation, in which the lanes register their results, and raises
// done for one cycle. Assumes N_IN >= 1.
module dle_sequencer #(
    parameter int N_IN = 8,
    parameter int CW   = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          in_valid,
    output logic          in_ready,
    output logic          accept,
    output logic          first,
    output logic          clear,
    output logic          load_out,
    output logic [CW-1:0] idx,
    output logic          done
);
    import dle_pkg::*;

    localparam logic [CW-1:0] LAST_IDX = CW'(N_IN - 1);

    run_state_t    state;
    logic [CW-1:0] cnt;
    logic          done_q;

    // Handshake and lane control decoded from the state.
    always_comb begin
        in_ready = (state == ST_RUN);
        accept   = in_ready && in_valid;
        first    = accept && (cnt == '0);
        clear    = start && (state == ST_IDLE);
        load_out = (state == ST_FIN);
        idx      = cnt;
        done     = done_q;
    end

    // State, element counter and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= (state == ST_FIN);
            case (state)
                ST_IDLE: if (start) begin
                    state <= ST_RUN;
                    cnt   <= '0;
                end
                ST_RUN: if (accept) begin
                    if (cnt == LAST_IDX) state <= ST_FIN;
                    else                 cnt   <= cnt + 1'b1;
                end
                ST_FIN:  state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/dle_requant.sv
// Output stage of one lane: ReLU, arithmetic right shift by SHIFT,
// clamp to 0..127. Purely combinational; assumes ACC_W > 8.
module dle_requant #(
    parameter int ACC_W = 16,
    parameter int SHIFT = 2
) (
    input  logic signed [ACC_W-1:0] acc,
    output logic        [7:0]       y
);
    logic signed [ACC_W-1:0] pos;
    logic        [ACC_W-1:0] shifted;

    // Zero negative sums, rescale, then saturate to seven bits.
    always_comb begin
        pos     = acc[ACC_W-1] ? '0 : acc;
        shifted = ACC_W'(pos >>> SHIFT);
        y       = (shifted > ACC_W'(127)) ? 8'd127 : {1'b0, shifted[6:0]};
    end

endmodule

// File: rtl/dle_lane.sv
// One neuron lane: constant weight column and bias, a wrapping signed
// accumulator and the registered requantised output byte. The bias is
// loaded on the first accepted element of a run.
module dle_lane #(
    parameter int LANE   = 0,
    parameter int N_USED = 3,
    parameter int ACC_W  = 16,
    parameter int BIAS_W = 16,
    parameter int SHIFT  = 2,
    parameter int CW     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              accept,
    input  logic              first,
    input  logic              load_out,
    input  logic [CW-1:0]     idx,
    input  logic signed [7:0] x,
    output logic [7:0]        y
);
    localparam logic signed [BIAS_W-1:0] BIAS =
        BIAS_W'(dle_pkg::bias_of(LANE, N_USED));
    localparam logic signed [ACC_W-1:0] BIAS_EXT = ACC_W'(BIAS);

    logic signed [7:0]       w;
    logic signed [15:0]      prod;
    logic signed [ACC_W-1:0] prod_ext;
    logic signed [ACC_W-1:0] acc;
    logic        [7:0]       y_next;

    // Weight lookup and product for the current element.
    always_comb begin
        w        = dle_pkg::weight_of(LANE, int'(idx), N_USED);
        prod     = x * w;
        prod_ext = ACC_W'(prod);
    end

    // Accumulator: cleared on start, bias plus product on the first element.
    always_ff @(posedge clk) begin
        if (!rst_n)      acc <= '0;
        else if (clear)  acc <= '0;
        else if (accept) acc <= (first ? BIAS_EXT : acc) + prod_ext;
    end

    dle_requant #(.ACC_W(ACC_W), .SHIFT(SHIFT)) u_requant (
        .acc (acc),
        .y   (y_next)
    );

    // Output register, written only in the finalisation cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)        y <= '0;
        else if (load_out) y <= y_next;
    end

endmodule

// File: rtl/dense_layer_engine.sv
// Top of the dense layer engine: one sequencer driving N_LANES parallel
// neuron lanes, one input element per accepted cycle. Lanes at index
// N_USED and above are padding with zero weights.
module dense_layer_engine #(
    parameter int N_IN    = 8,
    parameter int N_LANES = 4,
    parameter int N_USED  = 3,
    parameter int ACC_W   = 16,
    parameter int BIAS_W  = 16,
    parameter int SHIFT   = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 in_valid,
    input  logic [7:0]           in_data,
    output logic                 in_ready,
    output logic                 done,
    output logic [8*N_LANES-1:0] out_vec
);
    localparam int CW = (N_IN > 1) ? $clog2(N_IN) : 1;

    logic          accept;
    logic          first;
    logic          clear;
    logic          load_out;
    logic [CW-1:0] idx;

    dle_sequencer #(.N_IN(N_IN), .CW(CW)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .accept   (accept),
        .first    (first),
        .clear    (clear),
        .load_out (load_out),
        .idx      (idx),
        .done     (done)
    );

    // One lane per output neuron, each with its own table column.
    for (genvar j = 0; j < N_LANES; j++) begin : g_lane
        dle_lane #(
            .LANE   (j),
            .N_USED (N_USED),
            .ACC_W  (ACC_W),
            .BIAS_W (BIAS_W),
            .SHIFT  (SHIFT),
            .CW     (CW)
        ) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .clear    (clear),
            .accept   (accept),
            .first    (first),
            .load_out (load_out),
            .idx      (idx),
            .x        (in_data),
            .y        (out_vec[8*j +: 8])
        );
    end

endmodule

// File: rtl/dense_layer_engine_checker.sv
// Property checker for the dense layer engine, watching its ports only.
// It keeps its own count of accepted elements to know when the last
// element of a run has gone in.
module dense_layer_engine_checker #(
    parameter int N_IN    = 8,
    parameter int N_LANES = 4,
    parameter int N_USED  = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic                 in_ready,
    input logic                 done,
    input logic [8*N_LANES-1:0] out_vec
);
    localparam int BW = $clog2(N_IN + 1);

    logic [BW-1:0] beats;
    logic          pending;
    logic          hs;
    logic          last_hs;

    assign hs      = in_valid && in_ready;
    assign last_hs = hs && (beats == BW'(N_IN - 1));

    // Count handshakes within a run; flag the wait between last element and done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beats   <= '0;
            pending <= 1'b0;
        end else begin
            if (last_hs)  beats <= '0;
            else if (hs)  beats <= beats + 1'b1;
            if (last_hs)   pending <= 1'b1;
            else if (done) pending <= 1'b0;
        end
    end

    // Output bytes stay in range; padded lanes stay zero.
    always_comb begin
        if (rst_n) begin
            for (int j = 0; j < N_LANES; j++) begin
                AST_OUT_RANGE: assert (out_vec[8*j+7] == 1'b0);  // R6
                if (j >= N_USED) begin
                    AST_PAD_ZERO: assert (out_vec[8*j +: 8] == 8'd0);  // R10
                end
            end
        end
    end

    AST_LAST_TO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        last_hs |-> ##2 done);  // R7
    AST_READY_LOW_FINAL: assert property (@(posedge clk) disable iff (!rst_n)
        pending |-> !in_ready);  // R7
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);  // R7
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(out_vec) |-> done);  // R8
    AST_NO_EXTRA_BEATS: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (beats == '0));  // R3

endmodule

bind dense_layer_engine dense_layer_engine_checker #(
    .N_IN    (N_IN),
    .N_LANES (N_LANES),
    .N_USED  (N_USED)
) u_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .done     (done),
    .out_vec  (out_vec)
);

// File: tb/dense_layer_engine_bench.sv
// Directed bench for the dense layer engine: one task per scenario,
// each comparing against a model written from the requirements.
module dense_layer_engine_bench;
    localparam int N_IN    = 8;
    localparam int N_LANES = 4;
    localparam int N_USED  = 3;
    localparam int SHIFT   = 2;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 start = 1'b0;
    logic                 in_valid = 1'b0;
    logic [7:0]           in_data = '0;
    logic                 in_ready;
    logic                 done;
    logic [8*N_LANES-1:0] out_vec;

    int n_tests = 0;
    int n_fail  = 0;
    logic [7:0] xs [N_IN];

    always #10 clk = ~clk;  // 50 MHz

    dense_layer_engine #(
        .N_IN(N_IN), .N_LANES(N_LANES), .N_USED(N_USED), .SHIFT(SHIFT)
    ) u_dense_layer_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
        .in_data(in_data), .in_ready(in_ready), .done(done), .out_vec(out_vec)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Expected byte of lane j for the current xs (R4, R5, R6, R10).
    function automatic int model_lane(input int j);
        logic signed [15:0] acc;
        int w, v;
        if (j >= N_USED) return 0;
        acc = 16'(24 * j - 40);
        for (int k = 0; k < N_IN; k++) begin
            w   = ((3 * j + 5 * k) % 11) - 5;
            acc = acc + 16'($signed(xs[k]) * w);
        end
        if (acc < 0) return 0;
        v = int'(acc) / (1 << SHIFT);
        return (v > 127) ? 127 : v;
    endfunction

    // Open a run, feed xs with optional gaps and a stray start, check timing and results.
    task automatic run_layer(input string tag, input int gap_every, input int poke_at);
        int k = 0;
        int cyc = 0;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check({tag, " R2 ready after start"}, int'(in_ready), 1);
        while (k < N_IN) begin
            in_valid = !(gap_every > 0 && (cyc % gap_every) == gap_every - 1);
            in_data  = xs[k];
            start    = (k == poke_at);
            if (in_valid && in_ready) k++;
            @(negedge clk);
            cyc++;
        end
        in_valid = 1'b1;  // offered but must not be taken
        in_data  = 8'h7f;
        start    = 1'b0;
        check({tag, " R7 ready low after last"}, int'(in_ready), 0);
        check({tag, " R7 no early done"}, int'(done), 0);
        @(negedge clk);
        check({tag, " R7 done two cycles after last"}, int'(done), 1);
        for (int j = 0; j < N_LANES; j++)
            check({tag, " R4 lane result"}, int'(out_vec[8*j +: 8]), model_lane(j));
        @(negedge clk);
        check({tag, " R7 done one cycle"}, int'(done), 0);
        in_valid = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 ready", int'(in_ready), 0);
        check("R1 done", int'(done), 0);
        check("R1 out", int'(out_vec), 0);
    endtask

    task automatic t_zero_inputs();
        for (int k = 0; k < N_IN; k++) xs[k] = 8'd0;
        run_layer("zeros R5 bias only", 0, -1);
        check("R5 negative bias gives 0", int'(out_vec[7:0]), 0);
        check("R5 lane2 bias 8 shifted", int'(out_vec[23:16]), 2);
    endtask

    task automatic t_ramp();
        for (int k = 0; k < N_IN; k++) xs[k] = 8'(k * 10 - 30);
        run_layer("ramp R4", 0, -1);
    endtask

    task automatic t_gaps();
        for (int k = 0; k < N_IN; k++) xs[k] = 8'(20 - 7 * k);
        run_layer("gaps R3", 3, -1);
    endtask

    task automatic t_saturate();
        for (int k = 0; k < N_IN; k++) xs[k] = 8'd127;
        run_layer("max R6", 2, -1);
        for (int k = 0; k < N_IN; k++) xs[k] = 8'h80;
        run_layer("min R6", 0, -1);
    endtask

    task automatic t_start_busy();
        for (int k = 0; k < N_IN; k++) xs[k] = 8'(k * k - 9);
        run_layer("stray start R9", 0, 4);
    endtask

    // Idle data and cycles: nothing accepted, outputs held (R2, R8).
    task automatic t_idle_hold();
        logic [8*N_LANES-1:0] snap = out_vec;
        for (int i = 0; i < 6; i++) begin
            in_valid = 1'b1;
            in_data  = 8'(50 + i);
            @(negedge clk);
            check("R2 ready low while idle", int'(in_ready), 0);
        end
        in_valid = 1'b0;
        check("R8 outputs hold idle", int'(out_vec == snap), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_zero_inputs();
        t_ramp();
        t_gaps();
        t_saturate();
        t_start_busy();
        t_idle_hold();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule